// File: doc/BRIEF.md
# Near-Memory Read-Modify-Write Engine

This block sits beside a single-port synchronous RAM and performs a whole read-modify-write for a requester that sends one command. The command carries a word address, an opcode and a 64-bit operand. The engine reads the stored codeword, checks it and repairs it with a SECDED code, applies the operation, re-encodes the result and writes it back to the same address. The stored word never travels back to the requester. Each command ends with one response cycle that reports an ECC status and, for compares, the ordering of the stored value against the operand.

A statistics opcode updates a counter pair in one command: the even word of a two-word slot accumulates a byte length and the odd word counts packets. With the default 64-word RAM this gives 32 independent ports. The engine also keeps a saturating count of corrected words and a sticky flag, both visible at all times on the response side.

The RAM sits outside the block and is reached through a simple port with one-cycle read latency. The engine takes one command at a time, so a following command to the same address always sees the finished write-back.

Top module: `rmw_engine`

## Requirements
- R1: A command is accepted in a cycle where `cmd_valid` and `cmd_ready` are both high. In that same cycle a RAM read of the target word is issued. For non-statistics opcodes, any write-back goes to the same address two cycles later. `rsp_valid` is high for exactly one cycle, in the cycle after the write-back slot.
- R2: Each stored word is a 72-bit codeword. Bit 0 makes the parity of the whole word even. Bits 1, 2, 4, 8, 16, 32 and 64 are check bits. Check bit 2^k makes the XOR of all positions 1..71 whose index has bit k set equal to zero. Data bits 0..63 fill the remaining positions 3, 5, 6, 7, 9 ... 71 in ascending order.
- R3: A single flipped bit in any of the 72 positions is repaired before the operation. The repaired value is the one modified and written back, and the response status is 01.
- R4: A double-bit error suppresses every write of the command, and the response status is 10. Status priority is 11 over 10 over 01 over 00 (clean).
- R5: Opcode 0 adds the operand to the stored word modulo 2^64.
- R6: Opcode 1 writes back the bitwise OR of the stored word and the operand. Opcode 2 writes back the bitwise AND.
- R7: Opcode 3 compares the stored word with the operand as unsigned values and writes nothing. `rsp_cmp` is 01 for less, 10 for greater and 00 for equal; it is 00 for every other opcode and for an uncorrectable read.
- R8: Opcode 4 clears address bit 0 to find the byte word and sets it to find the packet word. It reads both words on consecutive cycles and writes byte+operand, then packet+1, on consecutive cycles. If either word is uncorrectable, neither is written.
- R9: Opcodes 5 to 7 write nothing and return status 11.
- R10: Every corrected word adds one to `rsp_ce_count`, which saturates at all ones. The first correction sets `rsp_ce_sticky`, which stays set until reset.
- R11: After reset, `cmd_ready` is 1, `rsp_valid` is 0, `mem_en` is 0, and the correction count and sticky flag are 0.
- R12: `cmd_ready` stays low from acceptance through the response cycle. A command held valid during that time is neither accepted nor causes a RAM access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command taken this cycle |
| cmd_op | input | 3 | Opcode |
| cmd_addr | input | AW | Word address (slot for statistics) |
| cmd_operand | input | DW | Operand or byte length |
| rsp_valid | output | 1 | Response cycle |
| rsp_status | output | 2 | ECC / opcode status |
| rsp_cmp | output | 2 | Compare result |
| rsp_ce_count | output | CNT_W | Corrected-word count |
| rsp_ce_sticky | output | 1 | A correction has occurred |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write (else read) |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | CW | Codeword to write |
| mem_rdata | input | CW | Codeword read, one cycle after a read |

## Verification
The assertions assume that the RAM returns the addressed codeword on `mem_rdata` exactly one cycle after a read enable, and that no word holds more than two flipped bits. With three or more flips the code can miscorrect, and the no-write-on-uncorrectable property would no longer match the stored state. The bench RAM model keeps the one-cycle latency and only changes contents through the engine's write port or a preload between commands. Every injected error pattern has either one flipped bit or two.

// File: rtl/rmw_pkg.sv
// Shared opcodes, status codes, sequencer phases and code sizing for the
// read-modify-write engine. Assumes a Hamming SECDED layout with one extra
// overall parity bit at codeword position 0.
package rmw_pkg;
    localparam logic [2:0] OP_ADD  = 3'd0;
    localparam logic [2:0] OP_OR   = 3'd1;
    localparam logic [2:0] OP_AND  = 3'd2;
    localparam logic [2:0] OP_CMP  = 3'd3;
    localparam logic [2:0] OP_STAT = 3'd4;

    localparam logic [1:0] CMP_EQ = 2'b00;
    localparam logic [1:0] CMP_LT = 2'b01;
    localparam logic [1:0] CMP_GT = 2'b10;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIXED = 2'b01,
        ST_UNCOR = 2'b10,
        ST_BADOP = 2'b11
    } status_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CHK0, S_CHK1, S_MOD, S_WR1, S_RSP
    } phase_e;

    // Number of Hamming check bits needed to cover dw data bits.
    function automatic int hamming_bits(input int dw);
        int p;
        p = 0;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction
endpackage

// File: rtl/rmw_secded_enc.sv
// SECDED encoder: places data bits at non-power-of-two positions, fills the
// Hamming check bits, then sets bit 0 for even parity over the whole word.
// Assumes DW small enough that CW-1 fits the Hamming index space.
module rmw_secded_enc
    import rmw_pkg::*;
#(
    parameter  int DW = 64,
    localparam int PB = hamming_bits(DW),
    localparam int CW = DW + PB + 1
) (
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] code_o
);
    // Purpose: build the codeword combinationally.
    always_comb begin
        logic [CW-1:0] c;
        logic          par;
        int            j;
        c = '0;
        j = 0;
        for (int i = 1; i < CW; i++) begin
            if ((i & (i - 1)) != 0) begin
                c[i] = data_i[j];
                j++;
            end
        end
        for (int k = 0; k < PB; k++) begin
            par = 1'b0;
            for (int i = 1; i < CW; i++) begin
                if (i[k]) par ^= c[i];
            end
            c[1 << k] = par;
        end
        c[0]   = ^c[CW-1:1];
        code_o = c;
    end
endmodule

// File: rtl/rmw_secded_dec.sv
// SECDED checker/corrector: computes the position syndrome and overall
// parity, flips a single bad bit, flags double errors, and extracts data.
// Assumes at most two bits of a word are in error.
module rmw_secded_dec
    import rmw_pkg::*;
#(
    parameter  int DW = 64,
    localparam int PB = hamming_bits(DW),
    localparam int CW = DW + PB + 1
) (
    input  logic [CW-1:0] code_i,
    output logic [DW-1:0] data_o,
    output logic          single_o,
    output logic          double_o
);
    // Purpose: classify the error, repair it and strip the check bits.
    always_comb begin
        logic [PB-1:0] syn;
        logic [CW-1:0] f;
        int            j;
        syn = '0;
        for (int i = 1; i < CW; i++) begin
            if (code_i[i]) syn ^= i[PB-1:0];
        end
        f        = code_i;
        single_o = 1'b0;
        double_o = 1'b0;
        if (^code_i) begin
            if (int'(syn) < CW) begin
                f[syn]   = ~f[syn];
                single_o = 1'b1;
            end else begin
                double_o = 1'b1;
            end
        end else if (syn != '0) begin
            double_o = 1'b1;
        end
        data_o = '0;
        j = 0;
        for (int i = 1; i < CW; i++) begin
            if ((i & (i - 1)) != 0) begin
                data_o[j] = f[i];
                j++;
            end
        end
    end
endmodule

// File: rtl/rmw_alu.sv
// Modify stage: computes the write-back value of the primary word, the
// incremented packet word, the unsigned compare result and whether the
// opcode writes at all. Inputs are already ECC-corrected.
module rmw_alu
    import rmw_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [2:0]    op_i,
    input  logic [DW-1:0] word0_i,
    input  logic [DW-1:0] word1_i,
    input  logic [DW-1:0] operand_i,
    output logic [DW-1:0] res0_o,
    output logic [DW-1:0] res1_o,
    output logic [1:0]    cmp_o,
    output logic          wr_o
);
    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    // Purpose: select the operation result and its write intent.
    always_comb begin
        res0_o = word0_i;
        wr_o   = 1'b0;
        case (op_i)
            OP_ADD:  begin res0_o = word0_i + operand_i; wr_o = 1'b1; end
            OP_OR:   begin res0_o = word0_i | operand_i; wr_o = 1'b1; end
            OP_AND:  begin res0_o = word0_i & operand_i; wr_o = 1'b1; end
            OP_STAT: begin res0_o = word0_i + operand_i; wr_o = 1'b1; end
            default: begin res0_o = word0_i;             wr_o = 1'b0; end
        endcase
    end

    // Purpose: packet counter increment for the statistics pair.
    assign res1_o = word1_i + ONE;

    // Purpose: unsigned ordering of stored word against operand.
    always_comb begin
        if (word0_i < operand_i)      cmp_o = CMP_LT;
        else if (word0_i > operand_i) cmp_o = CMP_GT;
        else                          cmp_o = CMP_EQ;
    end
endmodule

// File: rtl/rmw_engine.sv
// Near-memory read-modify-write engine. Accepts one command at a time,
// reads the addressed codeword (and its pair word for statistics), corrects
// it, modifies it and writes the re-encoded result back to the same place.
// Assumes the external single-port RAM returns read data one cycle after a
// read enable and holds at most two bad bits per word.
module rmw_engine
    import rmw_pkg::*;
#(
    parameter  int DW    = 64,
    parameter  int AW    = 6,
    parameter  int CNT_W = 16,
    localparam int PB    = hamming_bits(DW),
    localparam int CW    = DW + PB + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2:0]       cmd_op,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [DW-1:0]    cmd_operand,
    output logic             rsp_valid,
    output logic [1:0]       rsp_status,
    output logic [1:0]       rsp_cmp,
    output logic [CNT_W-1:0] rsp_ce_count,
    output logic             rsp_ce_sticky,
    output logic             mem_en,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [CW-1:0]    mem_wdata,
    input  logic [CW-1:0]    mem_rdata
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    phase_e            state_q, state_d;
    logic [2:0]        op_q;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     opnd_q, word0_q, word1_q;
    logic              fix_q, unc_q;
    logic [1:0]        status_q, cmpres_q;
    logic [CNT_W-1:0]  ce_cnt_q;
    logic              ce_sticky_q;

    logic [DW-1:0]     dec_data, res0, res1, enc_in;
    logic              dec_single, dec_double;
    logic [1:0]        alu_cmp;
    logic              alu_wr, wr_ok, is_stat, in_check;
    logic [AW-1:0]     pair_addr;
    logic [CW-1:0]     enc_code;

    assign is_stat   = (op_q == OP_STAT);
    assign pair_addr = {addr_q[AW-1:1], 1'b1};
    assign wr_ok     = alu_wr && !unc_q;
    assign in_check  = (state_q == S_CHK0) || (state_q == S_CHK1);
    assign cmd_ready = (state_q == S_IDLE);

    rmw_secded_dec #(.DW(DW)) u_dec (
        .code_i   (mem_rdata),
        .data_o   (dec_data),
        .single_o (dec_single),
        .double_o (dec_double)
    );

    rmw_alu #(.DW(DW)) u_alu (
        .op_i      (op_q),
        .word0_i   (word0_q),
        .word1_i   (word1_q),
        .operand_i (opnd_q),
        .res0_o    (res0),
        .res1_o    (res1),
        .cmp_o     (alu_cmp),
        .wr_o      (alu_wr)
    );

    assign enc_in = (state_q == S_WR1) ? res1 : res0;

    rmw_secded_enc #(.DW(DW)) u_enc (
        .data_i (enc_in),
        .code_o (enc_code)
    );

    // Purpose: sequencer next phase.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE:  if (cmd_valid) state_d = S_CHK0;
            S_CHK0:  state_d = is_stat ? S_CHK1 : S_MOD;
            S_CHK1:  state_d = S_MOD;
            S_MOD:   state_d = (is_stat && wr_ok) ? S_WR1 : S_RSP;
            S_WR1:   state_d = S_RSP;
            S_RSP:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Purpose: drive the RAM port from the current phase.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = enc_code;
        case (state_q)
            S_IDLE: begin
                mem_en   = cmd_valid;
                mem_addr = (cmd_op == OP_STAT) ? {cmd_addr[AW-1:1], 1'b0} : cmd_addr;
            end
            S_CHK0: begin
                mem_en   = is_stat;
                mem_addr = pair_addr;
            end
            S_MOD: begin
                mem_en = wr_ok;
                mem_we = wr_ok;
            end
            S_WR1: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                mem_addr = pair_addr;
            end
            default: ;
        endcase
    end

    // Purpose: phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: capture the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= '0;
            addr_q <= '0;
            opnd_q <= '0;
        end else if (cmd_valid && cmd_ready) begin
            op_q   <= cmd_op;
            addr_q <= (cmd_op == OP_STAT) ? {cmd_addr[AW-1:1], 1'b0} : cmd_addr;
            opnd_q <= cmd_operand;
        end
    end

    // Purpose: latch corrected words and accumulate error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word0_q <= '0;
            word1_q <= '0;
            fix_q   <= 1'b0;
            unc_q   <= 1'b0;
        end else if (state_q == S_CHK0) begin
            word0_q <= dec_data;
            fix_q   <= dec_single;
            unc_q   <= dec_double;
        end else if (state_q == S_CHK1) begin
            word1_q <= dec_data;
            fix_q   <= fix_q | dec_single;
            unc_q   <= unc_q | dec_double;
        end
    end

    // Purpose: form the response fields in the modify phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= ST_CLEAN;
            cmpres_q <= CMP_EQ;
        end else if (state_q == S_MOD) begin
            if (op_q > OP_STAT)  status_q <= ST_BADOP;
            else if (unc_q)      status_q <= ST_UNCOR;
            else if (fix_q)      status_q <= ST_FIXED;
            else                 status_q <= ST_CLEAN;
            cmpres_q <= (op_q == OP_CMP && !unc_q) ? alu_cmp : CMP_EQ;
        end
    end

    // Purpose: saturating corrected-word counter and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_cnt_q    <= '0;
            ce_sticky_q <= 1'b0;
        end else if (in_check && dec_single) begin
            ce_sticky_q <= 1'b1;
            if (ce_cnt_q != CNT_MAX) ce_cnt_q <= ce_cnt_q + 1'b1;
        end
    end

    assign rsp_valid     = (state_q == S_RSP);
    assign rsp_status    = status_q;
    assign rsp_cmp       = cmpres_q;
    assign rsp_ce_count  = ce_cnt_q;
    assign rsp_ce_sticky = ce_sticky_q;

    // R4: no RAM write while the command carries an uncorrectable read
    a_r4_no_wb_on_unc: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> !unc_q);

    // R7: compare never writes
    a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (op_q != OP_CMP));

    // R1: single-word write-back lands where the read went two cycles earlier
    a_r1_wb_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && !is_stat) |-> (mem_addr == $past(mem_addr, 2)));

    // R1: response lasts one cycle
    a_r1_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: sticky flag never clears
    a_r10_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ce_sticky |=> rsp_ce_sticky);

    // R10: counter never decreases
    a_r10_cnt_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rsp_ce_count >= $past(rsp_ce_count)));

    // R8: packet word write directly follows the byte word write
    a_r8_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && is_stat && mem_addr[0]) |-> $past(mem_en && mem_we));
endmodule

// File: tb/sim_rmw_engine.sv
module sim_rmw_engine;
    localparam int DW = 64;
    localparam int AW = 6;
    localparam int CW = 72;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_operand = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_status, rsp_cmp;
    logic [15:0]   rsp_ce_count;
    logic          rsp_ce_sticky;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [CW-1:0] mem_wdata;
    logic [CW-1:0] mem_rdata = '0;

    logic          tb_wen = 1'b0;
    logic [AW-1:0] tb_waddr = '0;
    logic [CW-1:0] tb_wdata = '0;
    logic [CW-1:0] ram [64];

    logic [DW-1:0] gold [64];
    int            inj  [64];
    int            total = 0, bad = 0, exp_ce = 0, cyc = 0;
    bit            exp_sticky = 0;

    always #4 clk = ~clk;

    rmw_engine u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_operand(cmd_operand),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_cmp(rsp_cmp),
        .rsp_ce_count(rsp_ce_count), .rsp_ce_sticky(rsp_ce_sticky),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // RAM model: one-cycle read latency, bench preload port has priority.
    always @(posedge clk) begin
        if (tb_wen) ram[tb_waddr] <= tb_wdata;
        else if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr];
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            total++; bad++;
            $display("FAIL R1 watchdog actual=%0d expected<%0d", cyc, 60000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Reference encoder: position syndrome of the data bits becomes the check bits.
    function automatic logic [CW-1:0] tb_enc(input logic [DW-1:0] d);
        logic [CW-1:0] w;
        logic [6:0]    s;
        int            n;
        w = '0; s = '0; n = 0;
        for (int pos = 1; pos < CW; pos++) begin
            if ($countones(pos) > 1) begin
                w[pos] = d[n];
                if (d[n]) s = s ^ 7'(pos);
                n++;
            end
        end
        for (int k = 0; k < 7; k++) w[1 << k] = s[k];
        w[0] = ^w;
        return w;
    endfunction

    task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] v, input logic [CW-1:0] flips);
        @(negedge clk);
        tb_wen = 1'b1; tb_waddr = a; tb_wdata = tb_enc(v) ^ flips;
        @(negedge clk);
        tb_wen = 1'b0;
        gold[a] = v;
        inj[a]  = $countones(flips);
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [AW-1:0] addr,
                           input logic [DW-1:0] opd, input string tag);
        bit            stat, illeg, unc, wr;
        int            nfix;
        logic [AW-1:0] a0, a1;
        logic [DW-1:0] r0, r1;
        logic [1:0]    ecmp, est;
        stat  = (op == 3'd4);
        illeg = (op > 3'd4);
        a0    = stat ? {addr[AW-1:1], 1'b0} : addr;
        a1    = {addr[AW-1:1], 1'b1};
        unc   = (inj[a0] >= 2) || (stat && inj[a1] >= 2);
        nfix  = ((inj[a0] == 1) ? 1 : 0) + ((stat && inj[a1] == 1) ? 1 : 0);
        wr    = !illeg && (op != 3'd3) && !unc;
        case (op)
            3'd0, 3'd4: r0 = gold[a0] + opd;
            3'd1:       r0 = gold[a0] | opd;
            3'd2:       r0 = gold[a0] & opd;
            default:    r0 = gold[a0];
        endcase
        r1 = gold[a1] + 64'd1;
        if (op == 3'd3 && !unc)
            ecmp = (gold[a0] < opd) ? 2'b01 : ((gold[a0] > opd) ? 2'b10 : 2'b00);
        else
            ecmp = 2'b00;
        est = illeg ? 2'b11 : (unc ? 2'b10 : ((nfix > 0) ? 2'b01 : 2'b00));
        exp_ce = (exp_ce + nfix > 65535) ? 65535 : exp_ce + nfix;
        if (nfix > 0) exp_sticky = 1;

        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_operand = opd;
        #1;
        chk({tag, " R12 ready when idle"}, CW'(cmd_ready), CW'(1));
        chk({tag, " R1 read issued"}, CW'({mem_en, mem_we, mem_addr}), CW'({1'b1, 1'b0, a0}));

        @(negedge clk);
        cmd_op = 3'd0; cmd_operand = 64'hDEAD_BEEF_0BAD_F00D;
        #1;
        chk({tag, " R12 ready low while busy"}, CW'(cmd_ready), CW'(0));
        if (stat) chk({tag, " R8 pair read"}, CW'({mem_en, mem_we, mem_addr}), CW'({1'b1, 1'b0, a1}));
        else      chk({tag, " R12 no access while busy"}, CW'(mem_en), CW'(0));

        if (stat) begin
            @(negedge clk); #1;
            chk({tag, " R12 no access while busy"}, CW'(mem_en), CW'(0));
        end

        @(negedge clk); #1;
        if (wr) begin
            chk({tag, " R1 write-back slot"}, CW'({mem_en, mem_we, mem_addr}), CW'({1'b1, 1'b1, a0}));
            chk({tag, " write data"}, mem_wdata, tb_enc(r0));
        end else begin
            chk({tag, " no write"}, CW'(mem_en), CW'(0));
        end

        if (stat && wr) begin
            @(negedge clk); #1;
            chk({tag, " R8 packet write"}, CW'({mem_en, mem_we, mem_addr}), CW'({1'b1, 1'b1, a1}));
            chk({tag, " R8 packet data"}, mem_wdata, tb_enc(r1));
        end

        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        chk({tag, " R1 response valid"}, CW'(rsp_valid), CW'(1));
        chk({tag, " status"}, CW'(rsp_status), CW'(est));
        chk({tag, " R7 compare field"}, CW'(rsp_cmp), CW'(ecmp));
        chk({tag, " R10 count"}, CW'(rsp_ce_count), CW'(exp_ce));
        chk({tag, " R10 sticky"}, CW'(rsp_ce_sticky), CW'(exp_sticky));

        @(negedge clk); #1;
        chk({tag, " R1 response one cycle"}, CW'(rsp_valid), CW'(0));
        chk({tag, " R12 ready again"}, CW'(cmd_ready), CW'(1));

        if (wr) begin
            gold[a0] = r0; inj[a0] = 0;
            if (stat) begin gold[a1] = r1; inj[a1] = 0; end
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin gold[i] = '0; inj[i] = 0; ram[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R11 reset ready", CW'(cmd_ready), CW'(1));
        chk("R11 reset rsp_valid", CW'(rsp_valid), CW'(0));
        chk("R11 reset mem_en", CW'(mem_en), CW'(0));
        chk("R11 reset count", CW'(rsp_ce_count), CW'(0));
        chk("R11 reset sticky", CW'(rsp_ce_sticky), CW'(0));

        // R5 add, including wrap
        put(6'd3, 64'd100, '0);
        run_cmd(3'd0, 6'd3, 64'd23, "R5 add");
        run_cmd(3'd0, 6'd3, 64'd7, "R5 add back-to-back R12");
        put(6'd4, 64'hFFFF_FFFF_FFFF_FFFF, '0);
        run_cmd(3'd0, 6'd4, 64'd2, "R5 add wrap");

        // R6 logic ops
        put(6'd5, 64'hF0F0_0000_1234_5678, '0);
        run_cmd(3'd1, 6'd5, 64'h0F00_00FF_0000_0001, "R6 or");
        run_cmd(3'd2, 6'd5, 64'hFF00_FF00_FF00_FF0F, "R6 and");

        // R7 compare: less, equal, greater
        put(6'd7, 64'd500, '0);
        run_cmd(3'd3, 6'd7, 64'd900, "R7 cmp less");
        run_cmd(3'd3, 6'd7, 64'd500, "R7 cmp equal");
        run_cmd(3'd3, 6'd7, 64'd1, "R7 cmp greater");

        // R3 single error repaired before add; R10 counter
        put(6'd8, 64'd1000, 72'd1 << 40);
        run_cmd(3'd0, 6'd8, 64'd1, "R3 fix data bit");
        put(6'd9, 64'd77, 72'd1 << 0);
        run_cmd(3'd3, 6'd9, 64'd77, "R3 fix parity bit cmp");

        // R4 double error: no write, then compare reports 10 and 00
        put(6'd10, 64'd55, (72'd1 << 3) | (72'd1 << 60));
        run_cmd(3'd0, 6'd10, 64'd5, "R4 double add");
        run_cmd(3'd3, 6'd10, 64'd5, "R4 double cmp");

        // R8 statistics pair, slot at words 12/13
        put(6'd12, 64'd0, '0);
        put(6'd13, 64'd0, '0);
        run_cmd(3'd4, 6'd13, 64'd1500, "R8 stat first");
        run_cmd(3'd4, 6'd12, 64'd64, "R8 stat second");
        put(6'd13, 64'd2, 72'd1 << 17);
        run_cmd(3'd4, 6'd12, 64'd40, "R8 stat fixed packet word");
        put(6'd13, 64'd3, (72'd1 << 1) | (72'd1 << 2));
        run_cmd(3'd4, 6'd12, 64'd9, "R8 stat uncorrectable pair");

        // R9 unsupported opcodes
        put(6'd14, 64'd11, '0);
        run_cmd(3'd5, 6'd14, 64'd1, "R9 op5");
        run_cmd(3'd7, 6'd14, 64'd1, "R9 op7");

        // R2 / R3 every single-bit position corrected and re-encoded
        for (int b = 0; b < CW; b++) begin
            put(6'd20, 64'h5A5A_C3C3_0F0F_9669 ^ 64'(b), 72'd1 << b);
            run_cmd(3'd0, 6'd20, 64'(b * 3 + 1), "R2 R3 position sweep");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule